// File: doc/BRIEF.md
# Delayed-Read Target Controller

This block serves non-prefetchable reads that arrive on a parallel bus target and are satisfied by a single read on an on-chip memory-mapped master port. The block splits each read into two phases. In the request phase, it claims the read, records its address, command and byte enables, and tells the initiator to retry. The read then runs on the master side, and the returned word waits in a response register. In the completion phase, the initiator presents the same read again, and the block returns the stored word.

While a delayed read is outstanding, every claimed transaction is told to retry and nothing about it is kept. Completion is held back while a write travelling from the memory-mapped side toward the bus is still pending, so that the write stays ahead of the read. A latency timer starts when a read is accepted. If the word has not been collected when the timer runs out, the word is dropped and the path becomes free again. Address decode is reduced to a single hit input. The master address is formed by adding the offset inside the decoded window to a base value supplied on a configuration input.

The controller has four states: `S_IDLE`, `S_ISSUE` (master read asserted), `S_WAIT` (read accepted, waiting for data) and `S_HOLD` (word held, waiting for the repeat). Its transitions are:
- accept: `S_IDLE` to `S_ISSUE`
- issued: `S_ISSUE` to `S_WAIT`
- data back: `S_WAIT` to `S_HOLD`
- stale data: `S_WAIT` to `S_IDLE`
- complete: `S_HOLD` to `S_IDLE`
- expire: `S_HOLD` to `S_IDLE`

Top module: `dread_bridge`

## Requirements
- R1: After reset the block is in `S_IDLE`: `mm_read`, `rsp_retry` and `rsp_done` are low, and the timer and match registers are clear.
- R2: A read that hits (`req_valid`, `req_hit`, `req_read` high) while idle is accepted. `rsp_retry` pulses one cycle after the request. One master read is then issued at address `cfg_mm_base + req_addr[WIN_BITS-1:0]`, and the address bits above the window are ignored.
- R3: `mm_read` stays high with a stable `mm_addr` while `mm_waitrequest` is high. Exactly one master read is issued per accepted request.
- R4: A repeat that matches the stored request but arrives before the master data has returned is answered with retry and does not start another master read.
- R5: A repeat that matches in address, command and byte enables after the data has returned produces a one-cycle `rsp_done` with `rsp_data` equal to the returned word. The block is then idle and accepts a new read.
- R6: While a read is outstanding, any claimed transaction that differs in address, command or byte enables, or that is a write, gets retry and is not recorded. The original request can still complete afterwards.
- R7: While `ow_pending` is high, a matching repeat gets retry instead of completion. After `ow_pending` falls, the next matching repeat completes.
- R8: If the word is held for `TIMEOUT` clocks after acceptance without being collected, it is discarded. A later identical read is then treated as a new request: it gets retry and starts a new master read.
- R9: If the timer expires before the master data returns, the returned word is dropped on arrival, and the block goes to idle rather than holding the word.
- R10: A transaction without `req_hit`, or a write while idle, gets no response and starts no master read.
- R11: `rsp_retry` and `rsp_done` are single-cycle pulses that answer a request from the previous cycle. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A bus transaction is presented this cycle |
| req_read | input | 1 | Transaction is a read |
| req_hit | input | 1 | Transaction address falls in a decoded window |
| req_addr | input | AW | Bus address |
| req_cmd | input | CMD_W | Bus command code |
| req_be | input | BE_W | Byte enables |
| ow_pending | input | 1 | A write from the memory-mapped side toward the bus is still pending |
| cfg_mm_base | input | MAW | Memory-mapped base for the window |
| rsp_retry | output | 1 | Retry answer to last cycle's request |
| rsp_done | output | 1 | Completion with data for last cycle's request |
| rsp_data | output | DW | Read data, valid with `rsp_done` |
| mm_read | output | 1 | Master read request |
| mm_addr | output | MAW | Master read address |
| mm_waitrequest | input | 1 | Slave stalls the read request |
| mm_readdata | input | DW | Master read data |
| mm_readdatavalid | input | 1 | Master read data is valid |

## Verification
The bench builds the block with `TIMEOUT` = 64 instead of 32768. This makes both discard paths short enough to test: expiry while the word is held, and expiry while the master read is still outstanding. It uses `AW` = 16 with `WIN_BITS` = 12, so bus addresses with high bits set show that the translation drops everything outside the window. Its slave model stalls each read for two cycles and can hold back data for as long as needed.

// File: rtl/dread_pkg.sv
package dread_pkg;

    parameter int CMD_W = 4;
    parameter int BE_W  = 4;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_HOLD  = 2'd3
    } dr_state_e;

endpackage

// File: rtl/dread_timer.sv
module dread_timer #(
    parameter int unsigned TIMEOUT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == TW'(TIMEOUT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dread_match.sv
module dread_match
    import dread_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    in_addr,
    input  logic [CMD_W-1:0] in_cmd,
    input  logic [BE_W-1:0]  in_be,
    output logic             same
);
    logic [AW-1:0]    addr_q;
    logic [CMD_W-1:0] cmd_q;
    logic [BE_W-1:0]  be_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            be_q   <= '0;
        end else if (load) begin
            addr_q <= in_addr;
            cmd_q  <= in_cmd;
            be_q   <= in_be;
        end
    end

    assign same = (in_addr == addr_q) && (in_cmd == cmd_q) && (in_be == be_q);
endmodule

// File: rtl/dread_xlate.sv
module dread_xlate #(
    parameter int WIN_BITS = 16,
    parameter int MAW      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WIN_BITS-1:0] win_off,
    input  logic [MAW-1:0]      base,
    output logic [MAW-1:0]      mm_addr
);
    localparam int PAD = MAW - WIN_BITS;

    logic [MAW-1:0] sum;

    generate
        if (PAD > 0) begin : g_pad
            assign sum = base + {{PAD{1'b0}}, win_off};
        end else begin : g_nopad
            assign sum = base + win_off;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_addr <= '0;
        end else if (load) begin
            mm_addr <= sum;
        end
    end
endmodule

// File: rtl/dread_bridge.sv
module dread_bridge
    import dread_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          WIN_BITS = 16,
    parameter int          MAW      = 32,
    parameter int          DW       = 32,
    parameter int unsigned TIMEOUT  = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic             req_hit,
    input  logic [AW-1:0]    req_addr,
    input  logic [CMD_W-1:0] req_cmd,
    input  logic [BE_W-1:0]  req_be,
    input  logic             ow_pending,
    input  logic [MAW-1:0]   cfg_mm_base,
    output logic             rsp_retry,
    output logic             rsp_done,
    output logic [DW-1:0]    rsp_data,
    output logic             mm_read,
    output logic [MAW-1:0]   mm_addr,
    input  logic             mm_waitrequest,
    input  logic [DW-1:0]    mm_readdata,
    input  logic             mm_readdatavalid
);
    dr_state_e state_q, state_d;

    logic          claim;
    logic          rd_hit;
    logic          same_req;
    logic          accept;
    logic          complete;
    logic          expired;
    logic [DW-1:0] rdata_q;

    assign claim    = req_valid && req_hit;
    assign rd_hit   = claim && req_read;
    assign accept   = (state_q == S_IDLE) && rd_hit;
    assign complete = (state_q == S_HOLD) && rd_hit && same_req
                      && !ow_pending && !expired;
    assign mm_read  = (state_q == S_ISSUE);

    dread_match #(.AW(AW)) i_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .in_addr (req_addr),
        .in_cmd  (req_cmd),
        .in_be   (req_be),
        .same    (same_req)
    );

    dread_xlate #(.WIN_BITS(WIN_BITS), .MAW(MAW)) i_xlate (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .win_off (req_addr[WIN_BITS-1:0]),
        .base    (cfg_mm_base),
        .mm_addr (mm_addr)
    );

    dread_timer #(.TIMEOUT(TIMEOUT)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .run     (state_q != S_IDLE),
        .expired (expired)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept)            state_d = S_ISSUE;
            S_ISSUE: if (!mm_waitrequest)   state_d = S_WAIT;
            S_WAIT:  if (mm_readdatavalid)  state_d = expired ? S_IDLE : S_HOLD;
            S_HOLD:  if (expired || complete) state_d = S_IDLE;
            default:                        state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // response word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if ((state_q == S_WAIT) && mm_readdatavalid) begin
            rdata_q <= mm_readdata;
        end
    end

    // bus-side answers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_retry <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_retry <= (state_q == S_IDLE) ? rd_hit : (claim && !complete);
            rsp_done  <= complete;
            if (complete) rsp_data <= rdata_q;
        end
    end
endmodule

// File: rtl/dread_bridge_chk.sv
module dread_bridge_chk #(
    parameter int MAW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_read,
    input logic           req_hit,
    input logic           ow_pending,
    input logic           rsp_retry,
    input logic           rsp_done,
    input logic           mm_read,
    input logic [MAW-1:0] mm_addr,
    input logic           mm_waitrequest
);
    AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_retry && rsp_done)); // R11

    AST_RETRY_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> $past(req_valid && req_hit)); // R11

    AST_MM_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mm_read && mm_waitrequest |=> mm_read && $stable(mm_addr)); // R3

    AST_DONE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(req_valid && req_hit && req_read)); // R5

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !$past(ow_pending)); // R7

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_hit |=> !rsp_retry && !rsp_done); // R10
endmodule

bind dread_bridge dread_bridge_chk #(.MAW(MAW)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_read       (req_read),
    .req_hit        (req_hit),
    .ow_pending     (ow_pending),
    .rsp_retry      (rsp_retry),
    .rsp_done       (rsp_done),
    .mm_read        (mm_read),
    .mm_addr        (mm_addr),
    .mm_waitrequest (mm_waitrequest)
);

// File: tb/test_dread_bridge.sv
module test_dread_bridge;
    localparam int AW = 16, WIN = 12, MAW = 32, DW = 32, TMO = 64;
    localparam int K_NONE = 0, K_RETRY = 1, K_DONE = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_valid = 0, req_read = 0, req_hit = 0, ow_pending = 0;
    logic [AW-1:0]  req_addr = '0;
    logic [3:0]     req_cmd = '0, req_be = '0;
    logic [MAW-1:0] cfg_mm_base = 32'h8000_0000;
    logic rsp_retry, rsp_done, mm_read;
    logic [DW-1:0]  rsp_data;
    logic [MAW-1:0] mm_addr;
    logic mm_waitrequest = 0, mm_readdatavalid = 0;
    logic [DW-1:0]  mm_readdata = '0;

    dread_bridge #(.AW(AW), .WIN_BITS(WIN), .MAW(MAW), .DW(DW), .TIMEOUT(TMO)) i_dread_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_hit(req_hit), .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be),
        .ow_pending(ow_pending), .cfg_mm_base(cfg_mm_base), .rsp_retry(rsp_retry),
        .rsp_done(rsp_done), .rsp_data(rsp_data), .mm_read(mm_read), .mm_addr(mm_addr),
        .mm_waitrequest(mm_waitrequest), .mm_readdata(mm_readdata),
        .mm_readdatavalid(mm_readdatavalid)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // slave model: two stall cycles, data three cycles after acceptance
    int wr_cnt = 0, dv_cnt = 0, mm_reads = 0;
    bit mm_hold = 0;
    logic [MAW-1:0] mm_last = '0;
    logic [DW-1:0]  mm_pend = '0;

    always @(negedge clk) begin
        mm_readdatavalid = 0;
        if (!rst_n) begin
            mm_waitrequest = 0; wr_cnt = 0; dv_cnt = 0;
        end else begin
            if (mm_read && wr_cnt < 2) begin
                mm_waitrequest = 1; wr_cnt++;
            end else begin
                mm_waitrequest = 0;
                if (!mm_read) wr_cnt = 0;
            end
            if (dv_cnt > 0 && !mm_hold) begin
                dv_cnt--;
                if (dv_cnt == 0) begin
                    mm_readdatavalid = 1; mm_readdata = mm_pend;
                end
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && mm_read && !mm_waitrequest) begin
            mm_reads++;
            mm_last = mm_addr;
            mm_pend = mm_addr ^ 32'h5A5A_0000;
            dv_cnt  = 3;
        end
    end

    // scoreboard
    typedef struct {
        int            stamp;
        int            kind;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t sb_q[$];

    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0 && sb_q[0].stamp <= cyc) begin
            exp_t it;
            it = sb_q.pop_front();
            if (it.stamp != cyc) begin
                check(0, it.tag, "response slot missed", 64'(cyc), 64'(it.stamp));
            end else begin
                case (it.kind)
                    K_NONE:  check(!rsp_retry && !rsp_done, it.tag, "no response",
                                   {62'd0, rsp_retry, rsp_done}, 64'd0);
                    K_RETRY: check(rsp_retry && !rsp_done, it.tag, "retry",
                                   {62'd0, rsp_retry, rsp_done}, 64'd2);
                    default: check(rsp_done && !rsp_retry && rsp_data == it.data, it.tag,
                                   "completion", {30'd0, rsp_retry, rsp_done, rsp_data},
                                   {32'd1, it.data});
                endcase
            end
        end
    end

    task automatic drive(input logic [AW-1:0] a, input logic [3:0] c, input logic [3:0] b,
                         input bit rd, input bit hit, input int kind,
                         input logic [DW-1:0] d, input string tag);
        exp_t e1, e2;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_cmd = c; req_be = b; req_read = rd; req_hit = hit;
        e1 = '{stamp: cyc + 1, kind: kind, data: d, tag: tag};
        e2 = '{stamp: cyc + 2, kind: K_NONE, data: '0, tag: "R11"};
        sb_q.push_back(e1);
        sb_q.push_back(e2);
        @(negedge clk);
        req_valid = 0; req_hit = 0; req_read = 0;
        @(negedge clk);
    endtask

    function automatic logic [MAW-1:0] xl(input logic [AW-1:0] a);
        return cfg_mm_base + MAW'(a & AW'((1 << WIN) - 1));
    endfunction

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return xl(a) ^ 32'h5A5A_0000;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int base_reads;
        logic [AW-1:0] A = 16'hF123, B = 16'h0456, C = 16'h3ABC, D = 16'h7010;
        repeat (3) @(negedge clk);
        check(!mm_read && !rsp_retry && !rsp_done, "R1", "outputs in reset",
              {61'd0, mm_read, rsp_retry, rsp_done}, 64'd0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(!mm_read && !rsp_retry && !rsp_done, "R1", "outputs after reset",
              {61'd0, mm_read, rsp_retry, rsp_done}, 64'd0);

        // R10: no hit, or a write, while idle
        base_reads = mm_reads;
        drive(A, 4'h6, 4'hF, 1, 0, K_NONE, '0, "R10");
        drive(A, 4'h7, 4'hF, 0, 1, K_NONE, '0, "R10");
        repeat (6) @(negedge clk);
        check(mm_reads == base_reads, "R10", "no master read", 64'(mm_reads), 64'(base_reads));

        // R2 / R4: accept A, then an early repeat
        drive(A, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R2");
        drive(A, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R4");
        repeat (10) @(negedge clk);
        check(mm_last == xl(A), "R2", "translated address", 64'(mm_last), 64'(xl(A)));
        check(mm_reads == base_reads + 1, "R3", "one master read", 64'(mm_reads),
              64'(base_reads + 1));

        // R6: differing transactions are retried and not recorded
        drive(A, 4'h6, 4'h3, 1, 1, K_RETRY, '0, "R6");
        drive(A ^ 16'h0004, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R6");
        drive(A, 4'hC, 4'hF, 1, 1, K_RETRY, '0, "R6");
        drive(B, 4'h7, 4'hF, 0, 1, K_RETRY, '0, "R6");

        // R7: pending opposite write withholds completion
        ow_pending = 1;
        drive(A, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R7");
        ow_pending = 0;
        drive(A, 4'h6, 4'hF, 1, 1, K_DONE, word_of(A), "R5");
        check(mm_reads == base_reads + 1, "R4", "no extra master read", 64'(mm_reads),
              64'(base_reads + 1));

        // R5: back to idle, new read B
        drive(B, 4'h6, 4'h1, 1, 1, K_RETRY, '0, "R5");
        repeat (10) @(negedge clk);
        check(mm_last == xl(B), "R2", "translated address B", 64'(mm_last), 64'(xl(B)));
        drive(B, 4'h6, 4'h1, 1, 1, K_DONE, word_of(B), "R5");

        // R8: timeout while held
        base_reads = mm_reads;
        drive(C, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R8");
        repeat (TMO + 10) @(negedge clk);
        drive(C, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R8");
        repeat (10) @(negedge clk);
        check(mm_reads == base_reads + 2, "R8", "reissued after discard", 64'(mm_reads),
              64'(base_reads + 2));
        drive(C, 4'h6, 4'hF, 1, 1, K_DONE, word_of(C), "R8");

        // R9: timeout before data returns
        base_reads = mm_reads;
        mm_hold = 1;
        drive(D, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R9");
        repeat (TMO + 10) @(negedge clk);
        drive(D, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R9");
        check(mm_reads == base_reads + 1, "R9", "still one read while stalled", 64'(mm_reads),
              64'(base_reads + 1));
        mm_hold = 0;
        repeat (8) @(negedge clk);
        drive(D, 4'h6, 4'hF, 1, 1, K_RETRY, '0, "R9");
        repeat (10) @(negedge clk);
        check(mm_reads == base_reads + 2, "R9", "stale word dropped, new read", 64'(mm_reads),
              64'(base_reads + 2));
        drive(D, 4'h6, 4'hF, 1, 1, K_DONE, word_of(D), "R9");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R11", "scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule